// File: doc/BRIEF.md
# Pipelined IDEA Cipher Datapath

This block is the data path of the IDEA block cipher, unrolled into a register pipeline. A 64-bit block enters with a table of 52 round keys of 16 bits each. The result leaves a fixed number of cycles later. The block can accept one new block on every clock. The cipher has eight identical rounds and a final output transformation. These are built only from three operations on 16-bit words: XOR, addition modulo 65536, and multiplication modulo 65537.

Encryption and decryption use the same hardware. Only the key table changes. The caller expands the 128-bit cipher key into the 52-word table, and inverts that table for decryption, outside this block. The key table travels down the pipeline with its block, so every block can use a different table.

Both edges of the block use valid/ready handshakes. A transfer happens on a rising clock edge when valid and ready are both high. Back-pressure works as a global stall. When the last stage holds a block and `out_ready_i` is low, every stage freezes and `in_ready_o` drops. `in_ready_o` is derived combinationally from `out_valid_o` and `out_ready_i`. Because of this, an upstream source must not make its valid depend on `in_ready_o`. A downstream sink may drop ready at any time.

Top module: `idea_pipe`

## Requirements
- R1: Modular multiplication treats a 16-bit operand of 0 as the value 65536, and returns 0 when the product modulo 65537 equals 65536. An all-zero key table and zero data words give results that follow this rule.
- R2: Word layout and round steps:
  - Data word 1 is `in_data_i[63:48]` and word 4 is `[15:0]`.
  - Key word j is `in_keys_i[16*j+15:16*j]`. Round r (0 to 7) uses words 6r to 6r+5, in the order mul, add, add, mul, mul, mul.
  - The standard vector gives ciphertext 11FB ED2B 0198 6DE5. Its key words are 0001..0008, expanded by 25-bit left rotations, and its plaintext is 0000 0001 0002 0003.
- R3: After the eighth round, words 48 to 51 are applied in the order multiply, add, add, multiply. The inner two words are used in their unswapped order. Random blocks under random key tables match the cipher equations.
- R4: A block accepted on clock edge n shows on `out_data_o` with `out_valid_o` high after edge n+8. It leaves on edge n+9 if `out_ready_i` stays high. The latency is ROUNDS+1 register stages.
- R5: While `out_ready_i` is high, `in_ready_o` stays high. A new block is accepted on every edge, and results come out on consecutive cycles.
- R6: A ciphertext sent with the inverted key table returns the original plaintext. The inverted table uses multiplicative inverses, additive negations, and a swap of the inner additive keys in rounds 2 to 8.
- R7: While `out_valid_o` is high and `out_ready_i` is low:
  - `in_ready_o` is low;
  - on the next cycle `out_valid_o` is still high and `out_data_o` is unchanged.
- R8: While `rst_ni` is low and right after it, `out_valid_o` is low and `in_ready_o` is high.
- R9: Each block is processed with the key table sampled on its own accepting edge, even when the table changes on every cycle. Results leave in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input block and key table are valid |
| in_ready_o | output | 1 | Pipeline can take a block this cycle |
| in_data_i | input | 64 | Input block, word 1 in the top 16 bits |
| in_keys_i | input | 832 | 52 key words, word j at bits 16*j+15:16*j |
| out_valid_o | output | 1 | Output block is valid |
| out_ready_i | input | 1 | Downstream takes the output block |
| out_data_o | output | 64 | Output block, word 1 in the top 16 bits |

## Verification
The zero operand of the multiplier is a main target. All-zero key tables and zero data words reach both multiplier branches. A multiplier that treats 0 as zero, or that returns 65536 unencoded, gives wrong ciphertext at once.

The fixed test vector and the decryption round trip catch several mistakes:
- a swap missing or doubled before the output transformation;
- key words taken in the wrong order.

A key table that changes on every cycle exposes keys that are not carried with their block. Random output back-pressure exposes stages that move while stalled: they would show a changed or lost result.

// File: rtl/idea_pkg.sv
package idea_pkg;
  localparam int WORD_W   = 16;
  localparam int BLOCK_W  = 4 * WORD_W;
  localparam int RKEY_N   = 6;
  localparam int OKEY_N   = 4;
  localparam int RKEY_W   = RKEY_N * WORD_W;
  localparam int OKEY_W   = OKEY_N * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t add16(input word_t a, input word_t b);
    return a + b;
  endfunction
endpackage

// File: rtl/idea_mulmod.sv
// Multiplication modulo 2^16+1, with 0 standing for 2^16 on both inputs and output.
module idea_mulmod
  import idea_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  output word_t p_o
);
  logic [2*WORD_W-1:0] prod;
  word_t lo, hi;

  always_comb begin
    prod = {{WORD_W{1'b0}}, a_i} * {{WORD_W{1'b0}}, b_i};
    lo   = prod[WORD_W-1:0];
    hi   = prod[2*WORD_W-1:WORD_W];
    if (a_i == '0) begin
      // 2^16 * b == -b (mod 2^16+1), i.e. 1 - b in the 16-bit encoding
      p_o = word_t'(1) - b_i;
    end else if (b_i == '0) begin
      p_o = word_t'(1) - a_i;
    end else begin
      // a*b = hi*2^16 + lo == lo - hi (mod 2^16+1)
      p_o = lo - hi + word_t'(lo < hi);
    end
  end
endmodule

// File: rtl/idea_round.sv
// One cipher round; the inner two result words leave swapped.
module idea_round
  import idea_pkg::*;
(
  input  logic [BLOCK_W-1:0] x_i,
  input  logic [RKEY_W-1:0]  k_i,
  output logic [BLOCK_W-1:0] y_o
);
  word_t x1, x2, x3, x4;
  word_t t1, t2, t3, t4, t5, t6, t7, t8, t9, s8;

  assign {x1, x2, x3, x4} = x_i;

  idea_mulmod u_m1 (.a_i(x1), .b_i(k_i[0*WORD_W +: WORD_W]), .p_o(t1));
  idea_mulmod u_m4 (.a_i(x4), .b_i(k_i[3*WORD_W +: WORD_W]), .p_o(t4));
  assign t2 = add16(x2, k_i[1*WORD_W +: WORD_W]);
  assign t3 = add16(x3, k_i[2*WORD_W +: WORD_W]);

  assign t5 = t1 ^ t3;
  assign t6 = t2 ^ t4;

  idea_mulmod u_m5 (.a_i(t5), .b_i(k_i[4*WORD_W +: WORD_W]), .p_o(t7));
  assign s8 = add16(t6, t7);
  idea_mulmod u_m6 (.a_i(s8), .b_i(k_i[5*WORD_W +: WORD_W]), .p_o(t8));
  assign t9 = add16(t7, t8);

  assign y_o = {t1 ^ t8, t3 ^ t8, t2 ^ t9, t4 ^ t9};
endmodule

// File: rtl/idea_outxf.sv
// Final transformation; takes the inner words back out of their swapped order.
module idea_outxf
  import idea_pkg::*;
(
  input  logic [BLOCK_W-1:0] x_i,
  input  logic [OKEY_W-1:0]  k_i,
  output logic [BLOCK_W-1:0] y_o
);
  word_t x1, x2, x3, x4, y1, y4;

  assign {x1, x2, x3, x4} = x_i;

  idea_mulmod u_m1 (.a_i(x1), .b_i(k_i[0*WORD_W +: WORD_W]), .p_o(y1));
  idea_mulmod u_m4 (.a_i(x4), .b_i(k_i[3*WORD_W +: WORD_W]), .p_o(y4));

  assign y_o = {y1,
                add16(x3, k_i[1*WORD_W +: WORD_W]),
                add16(x2, k_i[2*WORD_W +: WORD_W]),
                y4};
endmodule

// File: rtl/idea_pipe.sv
// Fully unrolled cipher pipeline: one register stage per round, one for the
// output transformation. Whole-pipe stall on output back-pressure. ROUNDS >= 2.
module idea_pipe
  import idea_pkg::*;
#(
  parameter  int ROUNDS = 8,
  localparam int NKEY   = RKEY_N * ROUNDS + OKEY_N,
  localparam int KEYW   = NKEY * WORD_W,
  localparam int LAT    = ROUNDS + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [BLOCK_W-1:0] in_data_i,
  input  logic [KEYW-1:0]    in_keys_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [BLOCK_W-1:0] out_data_o
);
  logic               stall;
  logic               accept;
  logic [LAT:1]       vld_q;
  logic [BLOCK_W-1:0] blk_q [1:LAT];
  logic [KEYW-1:0]    key_q [1:ROUNDS-1];
  logic [OKEY_W-1:0]  okey_q;
  logic [BLOCK_W-1:0] nxt   [LAT];
  logic               unused_key_lo;

  assign stall      = vld_q[LAT] & ~out_ready_i;
  assign in_ready_o = ~stall;
  assign accept     = in_valid_i & in_ready_o;

  for (genvar s = 0; s < ROUNDS; s++) begin : g_rnd
    logic [BLOCK_W-1:0] x;
    logic [RKEY_W-1:0]  k;
    if (s == 0) begin : g_head
      assign x = in_data_i;
      assign k = in_keys_i[RKEY_W-1:0];
    end else begin : g_body
      assign x = blk_q[s];
      assign k = key_q[s][RKEY_W*s +: RKEY_W];
    end
    idea_round u_round (.x_i(x), .k_i(k), .y_o(nxt[s]));
  end

  idea_outxf u_outxf (.x_i(blk_q[ROUNDS]), .k_i(okey_q), .y_o(nxt[ROUNDS]));

  // Words of the last carried table already consumed by earlier rounds.
  assign unused_key_lo = ^key_q[ROUNDS-1][RKEY_W*(ROUNDS-1)-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (!stall) begin
      vld_q <= {vld_q[LAT-1:1], accept};
    end
  end

  always_ff @(posedge clk_i) begin
    if (!stall) begin
      for (int s = 0; s < LAT; s++) begin
        blk_q[s+1] <= nxt[s];
      end
      key_q[1] <= in_keys_i;
      for (int s = 1; s < ROUNDS - 1; s++) begin
        key_q[s+1] <= key_q[s];
      end
      okey_q <= key_q[ROUNDS-1][RKEY_W*ROUNDS +: OKEY_W];
    end
  end

  assign out_valid_o = vld_q[LAT];
  assign out_data_o  = blk_q[LAT];
endmodule

// File: rtl/idea_pipe_chk.sv
module idea_pipe_chk #(
  parameter int LAT = 9
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [63:0] out_data_o
);
  logic [LAT-1:0] acc_sh;
  logic           held;

  assign held = out_valid_o & ~out_ready_i;

  // Port-level model of where accepted blocks sit; advances only when not held.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_sh <= '0;
    end else if (!held) begin
      acc_sh <= {acc_sh[LAT-2:0], in_valid_i & in_ready_o};
    end
  end

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == acc_sh[LAT-1]);

  p_free_flow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  p_hold_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held |=> (out_valid_o && $stable(out_data_o)));

  p_block_input_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held |-> !in_ready_o);

  p_idle_after_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_sh == '0) |-> !out_valid_o);
endmodule

bind idea_pipe idea_pipe_chk #(.LAT(ROUNDS + 1)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_o (out_data_o)
);

// File: tb/idea_pipe_tb_top.sv
`timescale 1ns/1ps
module idea_pipe_tb_top;
  localparam int KW  = 52 * 16;
  localparam int LAT = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [63:0]   in_data = '0;
  logic [KW-1:0] in_keys = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [63:0]   out_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int waited = 0;
  bit lat_mode = 1'b0;
  bit rand_rdy = 1'b0;
  bit done = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  int          acc_q[$];

  always #2 clk = ~clk;  // 250 MHz

  idea_pipe dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_keys_i(in_keys),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference arithmetic ----------------
  function automatic logic [15:0] mm(input logic [15:0] a, input logic [15:0] b);
    longint unsigned aa, bb, r;
    aa = (a == 0) ? 64'd65536 : {48'd0, a};
    bb = (b == 0) ? 64'd65536 : {48'd0, b};
    r  = (aa * bb) % 64'd65537;
    return (r == 64'd65536) ? 16'd0 : r[15:0];
  endfunction

  function automatic logic [15:0] minv(input logic [15:0] x);
    longint unsigned base, r;
    int e;
    if (x <= 16'd1) return x;
    base = {48'd0, x};
    r = 1;
    e = 65535;
    while (e > 0) begin
      if (e[0]) r = (r * base) % 64'd65537;
      base = (base * base) % 64'd65537;
      e = e >> 1;
    end
    return r[15:0];
  endfunction

  function automatic logic [63:0] ref_idea(input logic [63:0] x, input logic [KW-1:0] k);
    logic [15:0] a, b, c, d, p, q, u;
    {a, b, c, d} = x;
    for (int r = 0; r < 8; r++) begin
      a = mm(a, k[16*(6*r) +: 16]);
      b = b + k[16*(6*r+1) +: 16];
      c = c + k[16*(6*r+2) +: 16];
      d = mm(d, k[16*(6*r+3) +: 16]);
      p = mm(a ^ c, k[16*(6*r+4) +: 16]);
      q = mm((b ^ d) + p, k[16*(6*r+5) +: 16]);
      p = p + q;
      a = a ^ q; c = c ^ q; b = b ^ p; d = d ^ p;
      if (r < 7) begin u = b; b = c; c = u; end
    end
    return {mm(a, k[16*48 +: 16]), b + k[16*49 +: 16],
            c + k[16*50 +: 16], mm(d, k[16*51 +: 16])};
  endfunction

  function automatic logic [KW-1:0] sched(input logic [127:0] key);
    logic [127:0] kk;
    logic [KW-1:0] f;
    kk = key;
    f = '0;
    for (int i = 0; i < 52; i++) begin
      if (i > 0 && i % 8 == 0) kk = {kk[102:0], kk[127:103]};
      f[16*i +: 16] = kk[127-16*(i%8) -: 16];
    end
    return f;
  endfunction

  function automatic logic [KW-1:0] invert(input logic [KW-1:0] ek);
    logic [KW-1:0] dk;
    int e;
    dk = '0;
    for (int r = 0; r < 9; r++) begin
      e = 6 * (8 - r);
      dk[16*(6*r) +: 16]   = minv(ek[16*e +: 16]);
      if (r == 0 || r == 8) begin
        dk[16*(6*r+1) +: 16] = 16'd0 - ek[16*(e+1) +: 16];
        dk[16*(6*r+2) +: 16] = 16'd0 - ek[16*(e+2) +: 16];
      end else begin
        dk[16*(6*r+1) +: 16] = 16'd0 - ek[16*(e+2) +: 16];
        dk[16*(6*r+2) +: 16] = 16'd0 - ek[16*(e+1) +: 16];
      end
      dk[16*(6*r+3) +: 16] = minv(ek[16*(e+3) +: 16]);
      if (r < 8) begin
        dk[16*(6*r+4) +: 16] = ek[16*(6*(7-r)+4) +: 16];
        dk[16*(6*r+5) +: 16] = ek[16*(6*(7-r)+5) +: 16];
      end
    end
    return dk;
  endfunction

  function automatic logic [KW-1:0] rand_table(input int zero_pct);
    logic [KW-1:0] t;
    for (int i = 0; i < 52; i++) begin
      t[16*i +: 16] = (($urandom % 100) < zero_pct) ? 16'd0 : 16'($urandom);
    end
    return t;
  endfunction

  function automatic logic [127:0] rand_key();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // ---------------- driver ----------------
  task automatic send(input logic [63:0] d, input logic [KW-1:0] k,
                      input logic [63:0] e, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_keys  = k;
    while (!in_ready) begin
      waited++;
      @(negedge clk);
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    acc_q.push_back(cyc + 1);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // ---------------- ready driver ----------------
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = rand_rdy ? 1'($urandom % 2) : 1'b1;
    end
  end

  // ---------------- monitor / scoreboard ----------------
  bit          prev_held = 1'b0;
  logic [63:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_held) begin
        chk(out_valid === 1'b1, "R7 valid held", {63'd0, out_valid}, 64'd1);
        chk(out_data === prev_data, "R7 data held", out_data, prev_data);
      end
      if (out_valid && !out_ready)
        chk(in_ready === 1'b0, "R7 input blocked", {63'd0, in_ready}, 64'd0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected output", out_data, 64'd0);
        end else begin
          logic [63:0] e;
          string t;
          int a;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          a = acc_q.pop_front();
          chk(out_data === e, t, out_data, e);
          if (lat_mode)
            chk(cyc - a == LAT - 1, "R4 latency", 64'(cyc - a), 64'(LAT - 1));
        end
      end
      prev_held = out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R5 actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [KW-1:0] ek, dk, zk, kt;
    logic [63:0]   pt, ct;
    repeat (4) @(negedge clk);
    chk(out_valid === 1'b0, "R8 out_valid in reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk(in_ready === 1'b1, "R8 in_ready after reset", {63'd0, in_ready}, 64'd1);

    // Known vector, both directions
    ek = sched(128'h0001_0002_0003_0004_0005_0006_0007_0008);
    dk = invert(ek);
    chk(ref_idea(64'h0000_0001_0002_0003, ek) === 64'h11FB_ED2B_0198_6DE5,
        "R2 reference model vector", ref_idea(64'h0000_0001_0002_0003, ek),
        64'h11FB_ED2B_0198_6DE5);
    send(64'h0000_0001_0002_0003, ek, 64'h11FB_ED2B_0198_6DE5, "R2 known vector");
    send(64'h11FB_ED2B_0198_6DE5, dk, 64'h0000_0001_0002_0003, "R6 known vector decrypt");
    drain();

    // Zero operands everywhere
    zk = '0;
    send(64'h0, zk, ref_idea(64'h0, zk), "R1 zero key zero data");
    send(64'h0000_FFFF_0000_0001, zk, ref_idea(64'h0000_FFFF_0000_0001, zk), "R1 zero key mixed data");
    kt = rand_table(50);
    send(64'h0000_0000_1234_0000, kt, ref_idea(64'h0000_0000_1234_0000, kt), "R1 half-zero table");
    kt = '1;
    send(64'hFFFF_0000_FFFF_0000, kt, ref_idea(64'hFFFF_0000_FFFF_0000, kt), "R1 all-ones table");
    drain();

    // Random tables against the cipher equations
    for (int i = 0; i < 10; i++) begin
      kt = rand_table(5);
      pt = {$urandom, $urandom};
      send(pt, kt, ref_idea(pt, kt), "R3 random table");
    end
    drain();

    // Back-to-back stream with fixed latency
    lat_mode = 1'b1;
    waited = 0;
    for (int i = 0; i < 24; i++) begin
      kt = rand_table(3);
      pt = {$urandom, $urandom};
      send(pt, kt, ref_idea(pt, kt), "R5 streaming");
    end
    chk(waited == 0, "R5 no input wait", 64'(waited), 64'd0);
    drain();
    lat_mode = 1'b0;

    // Table changes every cycle: encrypt then decrypt with fresh keys
    for (int i = 0; i < 12; i++) begin
      ek = sched(rand_key());
      dk = invert(ek);
      pt = {$urandom, $urandom};
      ct = ref_idea(pt, ek);
      send(pt, ek, ct, "R9 per-block table encrypt");
      send(ct, dk, pt, "R6 per-block table decrypt");
    end
    drain();

    // Random back-pressure
    rand_rdy = 1'b1;
    for (int i = 0; i < 40; i++) begin
      ek = sched(rand_key());
      pt = {$urandom, $urandom};
      ct = ref_idea(pt, ek);
      send(pt, ek, ct, "R7 stalled encrypt");
      send(ct, invert(ek), pt, "R7 stalled decrypt");
    end
    drain();
    rand_rdy = 1'b0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all results delivered", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule